// File: doc/BRIEF.md
# DMA Page and Refresh Glue

This block joins a four-channel DMA controller with 16-bit addresses to a system bus with 20-bit addresses. It holds a small page register per channel. Software loads these registers through a four-offset register port. Whenever a channel is granted, the block puts that channel's page on the top address bits. It works out which channel owns the bus by watching the controller's active-low acknowledge lines. When no channel is granted, it keeps memory cycles off the bus.

The block also produces the memory-refresh request for channel 0. A timer output edge raises the request. The request drops when the controller runs channel 0's acknowledge write cycle. The controller's hold request passes straight through as a CPU halt and as the hold acknowledge. Channels 0 and 1 are always loaded together, so they share one page value.

Top module: `dma_page_glue`

## Requirements
- R1: After reset every page register holds zero, no channel is active (bus strobes low, reads return all ones), and `refreshReq` is low.
- R2: A page write (`pgSel` and `pgWr` high at a clock edge) with `pgOfs` = 1 loads channel 2's page, and with `pgOfs` = 2 loads channel 3's page. The page is the low `PAGE_W` bits of `pgWdata`.
- R3: A page write with `pgOfs` = 3 loads channels 0 and 1 with the same value. A page write with `pgOfs` = 0 changes no page.
- R4: `pgRdata` always reads all ones (8'hFF).
- R5: While a channel is active, `busAddr` equals that channel's 4-bit page in bits [19:16] and `dmaAddr` in bits [15:0]. Page bits written above bit 3 have no effect.
- R6: A channel becomes active in the cycle after its `dackN` bit is first sampled low; when several fall together the lowest index wins. The active channel is dropped in the cycle after its `dackN` bit is sampled high again. A rising `dackN` bit of a channel that is not active has no effect.
- R7: With no channel active, `busRd` and `busWr` stay low and `dmaRdata` is all ones. With a channel active, `busRd`/`busWr` follow `dmaMemRd`/`dmaMemWr`, `dmaRdata` follows `busRdata`, and `busWdata` follows `dmaWdata`.
- R8: `refreshReq` rises one clock after `timerOut` is first sampled high after being sampled low, if it was clear. A `timerOut` already high when reset is released does not count as a rise.
- R9: `refreshReq` clears one clock after `dmaIoWr` is sampled high while `dackN[0]` is low. This clear wins over a timer rise in the same cycle. `dmaIoWr` while `dackN[0]` is high has no effect.
- R10: `cpuHalt` and `holdAck` equal `holdReq` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pgSel | input | 1 | Page register port select |
| pgWr | input | 1 | Page register write strobe |
| pgOfs | input | 2 | Page register offset |
| pgWdata | input | DATA_W | Page write data |
| pgRdata | output | DATA_W | Page read data (all ones) |
| dackN | input | 4 | Active-low channel acknowledges |
| timerOut | input | 1 | Refresh timer output |
| dmaIoWr | input | 1 | Controller I/O write strobe of an acknowledge cycle |
| refreshReq | output | 1 | Channel 0 request |
| dmaAddr | input | ADDR_W | Controller memory address |
| dmaMemRd | input | 1 | Controller memory read |
| dmaMemWr | input | 1 | Controller memory write |
| dmaWdata | input | DATA_W | Controller write data |
| dmaRdata | output | DATA_W | Read data back to controller |
| busAddr | output | ADDR_W+PAGE_W | Bus address |
| busRd | output | 1 | Bus read |
| busWr | output | 1 | Bus write |
| busWdata | output | DATA_W | Bus write data |
| busRdata | input | DATA_W | Bus read data |
| holdReq | input | 1 | Controller hold request |
| cpuHalt | output | 1 | CPU halt |
| holdAck | output | 1 | Hold acknowledge to controller |

## Verification
The assertions assume that acknowledge lines come from a controller that grants at most one channel at a time. A hold on channel 0's line is assumed to last through its acknowledge write. The stimulus keeps to this: it lowers one acknowledge at a time, except in the deliberate same-cycle priority case. It raises `dmaIoWr` only in short pulses. The page sweep writes every offset with every 4-bit value, with junk in the upper bits, and probes each channel after every write.

// File: rtl/dmapg_pkg.sv
package dmapg_pkg;
  localparam int NUM_CH   = 4;
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam int OFS_W    = 2;

  typedef struct packed {
    logic [NUM_CH-1:0]   pageLoad;
    logic                chanValid;
    logic [CH_IDX_W-1:0] chanSel;
  } glueStrobe_t;

  // offset 1 -> ch2, 2 -> ch3, 3 -> ch0 and ch1, 0 -> nothing
  function automatic logic [NUM_CH-1:0] decodeOffset(input logic [OFS_W-1:0] ofs);
    logic [NUM_CH-1:0] sel;
    sel = '0;
    case (ofs)
      2'd1:    sel[2] = 1'b1;
      2'd2:    sel[3] = 1'b1;
      2'd3:    sel[1:0] = 2'b11;
      default: sel = '0;
    endcase
    return sel;
  endfunction
endpackage

// File: rtl/dmapg_ctrl.sv
module dmapg_ctrl
  import dmapg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               pgSel,
  input  logic               pgWr,
  input  logic [OFS_W-1:0]   pgOfs,
  input  logic [NUM_CH-1:0]  dackN,
  input  logic               timerOut,
  input  logic               dmaIoWr,
  output glueStrobe_t        strobe,
  output logic               refreshReq
);
  logic [NUM_CH-1:0]   dackPrevQ;
  logic [NUM_CH-1:0]   fallVec;
  logic [CH_IDX_W-1:0] firstFall;
  logic                anyFall;
  logic                chanValidQ;
  logic [CH_IDX_W-1:0] chanSelQ;
  logic                timerPrevQ;
  logic                refQ;
  logic                ackClr;
  logic                timerRise;

  assign fallVec = dackPrevQ & ~dackN;
  assign anyFall = |fallVec;

  always_comb begin
    firstFall = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (fallVec[i]) firstFall = CH_IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dackPrevQ  <= '1;
      chanValidQ <= 1'b0;
      chanSelQ   <= '0;
    end else begin
      dackPrevQ <= dackN;
      if (anyFall) begin
        chanValidQ <= 1'b1;
        chanSelQ   <= firstFall;
      end else if (chanValidQ && dackN[chanSelQ]) begin
        chanValidQ <= 1'b0;
      end
    end
  end

  assign ackClr    = dmaIoWr && !dackN[0];
  assign timerRise = timerOut && !timerPrevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerPrevQ <= 1'b1;
      refQ       <= 1'b0;
    end else begin
      timerPrevQ <= timerOut;
      if (ackClr)                 refQ <= 1'b0;
      else if (timerRise && !refQ) refQ <= 1'b1;
    end
  end

  assign refreshReq       = refQ;
  assign strobe.pageLoad  = (pgSel && pgWr) ? decodeOffset(pgOfs) : '0;
  assign strobe.chanValid = chanValidQ;
  assign strobe.chanSel   = chanSelQ;

  AST_FALL_CH0: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dackN[0]) |=> (chanValidQ && chanSelQ == '0)); // R6
  AST_DROP_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (chanValidQ && dackN[chanSelQ] && !anyFall) |=> !chanValidQ); // R6
  AST_REF_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refreshReq) |-> $past(timerOut)); // R8
  AST_REF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (dmaIoWr && !dackN[0]) |=> !refreshReq); // R9
  AST_OFS0_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (pgSel && pgWr && pgOfs == '0) |-> strobe.pageLoad == '0); // R3
endmodule

// File: rtl/dmapg_datapath.sv
module dmapg_datapath
  import dmapg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  glueStrobe_t              strobe,
  input  logic [DATA_W-1:0]        pgWdata,
  output logic [DATA_W-1:0]        pgRdata,
  input  logic [ADDR_W-1:0]        dmaAddr,
  input  logic                     dmaMemRd,
  input  logic                     dmaMemWr,
  input  logic [DATA_W-1:0]        dmaWdata,
  output logic [DATA_W-1:0]        dmaRdata,
  output logic [ADDR_W+PAGE_W-1:0] busAddr,
  output logic                     busRd,
  output logic                     busWr,
  output logic [DATA_W-1:0]        busWdata,
  input  logic [DATA_W-1:0]        busRdata
);
  localparam int BUS_AW = ADDR_W + PAGE_W;

  logic [PAGE_W-1:0] pageQ [NUM_CH];
  logic              unusedHigh;

  assign unusedHigh = ^pgWdata[DATA_W-1:PAGE_W];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_page
    always_ff @(posedge clk) begin
      if (!rstN)                   pageQ[ch] <= '0;
      else if (strobe.pageLoad[ch]) pageQ[ch] <= pgWdata[PAGE_W-1:0];
    end
  end

  assign pgRdata  = '1;
  assign busAddr  = BUS_AW'({pageQ[strobe.chanSel], dmaAddr});
  assign busRd    = dmaMemRd && strobe.chanValid;
  assign busWr    = dmaMemWr && strobe.chanValid;
  assign busWdata = dmaWdata;
  assign dmaRdata = strobe.chanValid ? busRdata : '1;

  AST_PAIR_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    pageQ[0] == pageQ[1]); // R3
  AST_LOAD_CH2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pageLoad[2] |=> pageQ[2] == $past(pgWdata[PAGE_W-1:0])); // R2
  AST_IDLE_NOBUS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.chanValid |-> (!busRd && !busWr)); // R7
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.chanValid |-> dmaRdata == '1); // R7
endmodule

// File: rtl/dma_page_glue.sv
module dma_page_glue
  import dmapg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pgSel,
  input  logic                     pgWr,
  input  logic [1:0]               pgOfs,
  input  logic [DATA_W-1:0]        pgWdata,
  output logic [DATA_W-1:0]        pgRdata,
  input  logic [3:0]               dackN,
  input  logic                     timerOut,
  input  logic                     dmaIoWr,
  output logic                     refreshReq,
  input  logic [ADDR_W-1:0]        dmaAddr,
  input  logic                     dmaMemRd,
  input  logic                     dmaMemWr,
  input  logic [DATA_W-1:0]        dmaWdata,
  output logic [DATA_W-1:0]        dmaRdata,
  output logic [ADDR_W+PAGE_W-1:0] busAddr,
  output logic                     busRd,
  output logic                     busWr,
  output logic [DATA_W-1:0]        busWdata,
  input  logic [DATA_W-1:0]        busRdata,
  input  logic                     holdReq,
  output logic                     cpuHalt,
  output logic                     holdAck
);
  glueStrobe_t strobe;

  dmapg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pgSel      (pgSel),
    .pgWr       (pgWr),
    .pgOfs      (pgOfs),
    .dackN      (dackN),
    .timerOut   (timerOut),
    .dmaIoWr    (dmaIoWr),
    .strobe     (strobe),
    .refreshReq (refreshReq)
  );

  dmapg_datapath #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pgWdata  (pgWdata),
    .pgRdata  (pgRdata),
    .dmaAddr  (dmaAddr),
    .dmaMemRd (dmaMemRd),
    .dmaMemWr (dmaMemWr),
    .dmaWdata (dmaWdata),
    .dmaRdata (dmaRdata),
    .busAddr  (busAddr),
    .busRd    (busRd),
    .busWr    (busWr),
    .busWdata (busWdata),
    .busRdata (busRdata)
  );

  // hold request passes straight through, R10
  assign cpuHalt = holdReq;
  assign holdAck = holdReq;
endmodule

// File: tb/dma_page_glue_test.sv
module dma_page_glue_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = 4;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pgSel = 0, pgWr = 0;
  logic [1:0] pgOfs = '0;
  logic [DATA_W-1:0] pgWdata = '0;
  logic [DATA_W-1:0] pgRdata;
  logic [3:0] dackN = 4'hF;
  logic timerOut = 0, dmaIoWr = 0;
  logic refreshReq;
  logic [ADDR_W-1:0] dmaAddr = '0;
  logic dmaMemRd = 0, dmaMemWr = 0;
  logic [DATA_W-1:0] dmaWdata = '0, dmaRdata, busWdata, busRdata = '0;
  logic [ADDR_W+PAGE_W-1:0] busAddr;
  logic busRd, busWr;
  logic holdReq = 0, cpuHalt, holdAck;

  int errors = 0;
  int checks = 0;
  logic [PAGE_W-1:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_page_glue #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .pgSel(pgSel), .pgWr(pgWr), .pgOfs(pgOfs),
    .pgWdata(pgWdata), .pgRdata(pgRdata), .dackN(dackN), .timerOut(timerOut),
    .dmaIoWr(dmaIoWr), .refreshReq(refreshReq), .dmaAddr(dmaAddr),
    .dmaMemRd(dmaMemRd), .dmaMemWr(dmaMemWr), .dmaWdata(dmaWdata),
    .dmaRdata(dmaRdata), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .holdReq(holdReq),
    .cpuHalt(cpuHalt), .holdAck(holdAck)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pageWrite(input logic [1:0] ofs, input logic [7:0] val);
    pgSel = 1; pgWr = 1; pgOfs = ofs; pgWdata = val;
    step();
    pgSel = 0; pgWr = 0;
    case (ofs)
      2'd1: model[2] = val[3:0];
      2'd2: model[3] = val[3:0];
      2'd3: begin model[0] = val[3:0]; model[1] = val[3:0]; end
      default: ;
    endcase
  endtask

  task automatic expectIdle(input string tag);
    dmaMemRd = 1; dmaMemWr = 1; busRdata = 8'h3C;
    #1;
    chk({tag, " busRd"}, 32'(busRd), 0);
    chk({tag, " busWr"}, 32'(busWr), 0);
    chk({tag, " dmaRdata"}, 32'(dmaRdata), 32'hFF);
    dmaMemRd = 0; dmaMemWr = 0;
  endtask

  task automatic expectChan(input int ch, input string tag);
    for (int k = 0; k < 3; k++) begin
      logic [15:0] a;
      a = 16'(k * 16'h5A3D + ch * 16'h1111 + 16'h00F0);
      dmaAddr = a; dmaMemRd = 1; busRdata = 8'(a ^ 16'h00A5);
      dmaWdata = 8'(a); dmaMemWr = 0;
      #1;
      chk({tag, " R5 busAddr"}, 32'(busAddr), {12'h0, model[ch], a});
      chk({tag, " R7 busRd"}, 32'(busRd), 1);
      chk({tag, " R7 dmaRdata"}, 32'(dmaRdata), 32'(8'(a ^ 16'h00A5)));
      chk({tag, " R7 busWdata"}, 32'(busWdata), 32'(8'(a)));
    end
    dmaMemRd = 0;
  endtask

  task automatic probeChan(input int ch);
    dackN = 4'hF & ~(4'(1) << ch);
    step();
    expectChan(ch, "R5");
    dackN = 4'hF;
    step();
    expectIdle("R6 R7 release");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    timerOut = 1;
    repeat (3) step();
    rstN = 1;
    step();
    step();
    // reset state, timer high at release is not a rise
    chk("R1 refreshReq", 32'(refreshReq), 0);
    chk("R8 no rise at release", 32'(refreshReq), 0);
    expectIdle("R1 idle");
    for (int ch = 0; ch < 4; ch++) probeChan(ch); // R1 pages zero
    timerOut = 0;

    // page reads all ones, R4
    for (int o = 0; o < 4; o++) begin
      pgSel = 1; pgOfs = 2'(o); #1;
      chk("R4 pgRdata", 32'(pgRdata), 32'hFF);
      step();
    end
    pgSel = 0;

    // sweep offsets and values, R2 R3 R5
    for (int v = 0; v < 16; v++) begin
      for (int o = 0; o < 4; o++) begin
        pageWrite(2'(o), {~4'(v + o), 4'(v + o)});
        for (int ch = 0; ch < 4; ch++) probeChan(ch);
      end
    end

    // set distinct pages for tracking tests
    pageWrite(2'd3, 8'h05);
    pageWrite(2'd1, 8'h0A);
    pageWrite(2'd2, 8'h0C);
    pageWrite(2'd0, 8'h0F); // R3 offset 0 no effect
    probeChan(0); probeChan(1); probeChan(2); probeChan(3);

    // R6 tracking: later fall takes over, inactive rise ignored
    dackN = 4'b1110; step();
    expectChan(0, "R6 ch0");
    dackN = 4'b1010; step();
    expectChan(2, "R6 ch2 takes");
    dackN = 4'b1011; step();
    expectChan(2, "R6 inactive rise ignored");
    dackN = 4'b1111; step();
    expectIdle("R6 active rise");
    dackN = 4'b0011; step();
    expectChan(2, "R6 lowest wins");
    dackN = 4'b1111; step();
    expectIdle("R6 drop");

    // R8 refresh set
    timerOut = 1; step();
    chk("R8 set on rise", 32'(refreshReq), 1);
    timerOut = 0; step();
    chk("R8 holds", 32'(refreshReq), 1);
    // R9 write while ch0 not acked: no clear
    dackN = 4'b1011; dmaIoWr = 1; step();
    dmaIoWr = 0;
    chk("R9 no clear other ch", 32'(refreshReq), 1);
    dackN = 4'b1111; step();
    dackN = 4'b1110; dmaIoWr = 1; step();
    dmaIoWr = 0;
    chk("R9 clear by ack write", 32'(refreshReq), 0);
    dackN = 4'b1111; step();
    // clear wins over simultaneous rise
    dackN = 4'b1110; step();
    timerOut = 1; dmaIoWr = 1; step();
    dmaIoWr = 0;
    chk("R9 clear wins", 32'(refreshReq), 0);
    step();
    chk("R8 high level no rise", 32'(refreshReq), 0);
    timerOut = 0; step();
    timerOut = 1; step();
    chk("R8 second rise", 32'(refreshReq), 1);
    dackN = 4'b1111; step();

    // R10 hold pass-through
    holdReq = 1; #1;
    chk("R10 cpuHalt", 32'(cpuHalt), 1);
    chk("R10 holdAck", 32'(holdAck), 1);
    step();
    holdReq = 0; #1;
    chk("R10 cpuHalt low", 32'(cpuHalt), 0);
    chk("R10 holdAck low", 32'(holdAck), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule